// File: doc/BRIEF.md
# Serial Divider Configuration Port

This block holds the active settings of a clock synthesizer's frequency dividers: a 9-bit reference (input) divide value, a 10-bit feedback divide value, a bandwidth-select bit and two test bits. The settings are written through a three-pin serial interface made of a serial clock, a serial data line and a load line. The pins are asynchronous to the block. Each pin passes through a two-flop synchronizer into the system clock domain, and edges are detected from the synchronized samples.

While the load line is low, bits shift into a 22-bit frame register and the active settings are left alone. A rising load edge copies the whole frame into the active settings at once. A falling load edge freezes them. While load stays high, every serial clock edge shifts in one bit and the active settings follow the frame register directly. A transferred reference value of zero becomes one, and a feedback value below four becomes four. A sticky flag records each such correction. A one-cycle pulse marks every change of the active settings.

Top module: `divcfg_serial_port`

## Requirements
- R1: After reset the outputs are: reference divide 1, feedback divide 32, bandwidth select 1 (normal), test bits 00, error flag 0, valid pulse 0.
- R2: A frame is 22 bits sent most significant first. The first bit is the bandwidth select. The next two bits are the test bits, high bit first. Then come the reference value bits 8 down to 0, then the feedback value bits 9 down to 0. Values up to 511 and 1023 are carried unchanged.
- R3: While load is low, serial clock edges shift data into the frame register and leave every active output unchanged.
- R4: A rising edge on load copies the frame register to the active outputs. The new values appear on the third system clock rising edge after the first edge that samples load high.
- R5: After load falls, further shifting leaves the active outputs unchanged until load rises again.
- R6: While load is high, each serial clock rising edge shifts one bit, and the active outputs take the new frame contents.
- R7: When the synchronized load rise and serial clock rise fall in the same system cycle, the active outputs take the frame contents after that cycle's shift.
- R8: A transferred reference value of 0 is replaced by 1.
- R9: A transferred feedback value below 4 is replaced by 4. Values of 4 and above pass unchanged.
- R10: The error flag rises on the update where R8 or R9 replaces a value. It then stays high until reset.
- R11: The valid output is high for exactly the one system cycle in which any active output first shows a changed value. An update that leaves every value unchanged gives no pulse.
- R12: The bandwidth output equals the transferred bandwidth bit, and the test outputs equal the two transferred test bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock; data is taken on its rising edge |
| ser_data_i | input | 1 | Serial data, most significant bit first |
| ser_load_i | input | 1 | Load line: rise transfers, high is transparent, fall freezes |
| r_div_o | output | 9 | Active reference divide value |
| m_div_o | output | 10 | Active feedback divide value |
| wide_bw_o | output | 1 | Bandwidth select: 1 normal, 0 narrow |
| test_bits_o | output | 2 | Active test bits |
| cfg_valid_o | output | 1 | One-cycle pulse when the active settings change |
| range_err_o | output | 1 | Sticky flag: a transferred value was corrected |

## Verification
A shift and a transfer can happen in the same system cycle. This occurs when the load line and the serial clock are seen rising together, or when the serial clock rises while load is already high. The bench drives both pins on the same clock edge after 21 bits of a frame have been sent. It expects the active settings to hold the complete 22-bit frame, which proves the transfer took the register after the shift. A behavioural model, run every cycle, also covers the transparent phase and the valid pulses.

// File: rtl/divcfg_pkg.sv
// Package: widths, the active-settings type, reset defaults and range limits
// shared by the serial divider configuration port.
package divcfg_pkg;
    localparam int R_W     = 9;
    localparam int M_W     = 10;
    localparam int TST_W   = 2;
    localparam int FRAME_W = 1 + TST_W + R_W + M_W;
    localparam int R_MIN   = 1;
    localparam int M_MIN   = 4;
    localparam int R_RESET = 1;
    localparam int M_RESET = 32;

    // Field order matches the frame: first bit in ends up most significant.
    typedef struct packed {
        logic             wide_bw;
        logic [TST_W-1:0] tst;
        logic [R_W-1:0]   r;
        logic [M_W-1:0]   m;
    } cfg_word_t;

    localparam cfg_word_t CFG_RESET = '{
        wide_bw: 1'b1,
        tst:     '0,
        r:       R_W'(R_RESET),
        m:       M_W'(M_RESET)
    };
endpackage

// File: rtl/divcfg_pin_sync.sv
// Module: divcfg_pin_sync
// Brings a vector of asynchronous pins into the clk domain through a chain of
// STAGES flops per bit. Assumes pins change slowly compared with clk.
module divcfg_pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] lvl_o
);
    logic [WIDTH-1:0] stg [STAGES];

    // Synchronizer chain: each stage takes the one before it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= pin_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign lvl_o = stg[STAGES-1];
endmodule

// File: rtl/divcfg_edge_det.sv
// Module: divcfg_edge_det
// Flags rising edges of already-synchronized signals, one clk cycle wide.
// Assumes inputs come from the synchronizer and are glitch free.
module divcfg_edge_det #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] prev_q;

    // Remember the previous level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/divcfg_frame_shifter.sv
// Module: divcfg_frame_shifter
// Serial frame register. Shifts one bit in at the LSB when shift_en is high.
// frame_nxt_o shows the contents as they will be after this cycle, so a
// transfer in the same cycle sees the freshly shifted bit.
module divcfg_frame_shifter #(
    parameter int FRAME_W = divcfg_pkg::FRAME_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               din,
    output logic [FRAME_W-1:0] frame_nxt_o
);
    logic [FRAME_W-1:0] frame_q;

    // Next contents: shifted on a serial clock edge, else held.
    always_comb begin
        frame_nxt_o = shift_en ? {frame_q[FRAME_W-2:0], din} : frame_q;
    end

    // Frame storage.
    always_ff @(posedge clk) begin
        if (!rst_n) frame_q <= '0;
        else        frame_q <= frame_nxt_o;
    end
endmodule

// File: rtl/divcfg_active_regs.sv
// Module: divcfg_active_regs
// Active divider settings. When upd_en is high, takes the frame with range
// correction, raises a one-cycle valid pulse if anything changed, and sets
// the sticky error flag when a value had to be corrected.
// Assumes the frame layout of divcfg_pkg::cfg_word_t.
module divcfg_active_regs
    import divcfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_en,
    input  logic [FRAME_W-1:0] frame_i,
    output cfg_word_t          word_o,
    output logic               valid_o,
    output logic               err_o
);
    cfg_word_t raw;
    cfg_word_t fixed;
    logic      r_low;
    logic      m_low;

    // Decode the frame and force each divide value into its legal range.
    always_comb begin
        raw   = cfg_word_t'(frame_i);
        r_low = (raw.r < R_W'(R_MIN));
        m_low = (raw.m < M_W'(M_MIN));
        fixed = raw;
        if (r_low) fixed.r = R_W'(R_MIN);
        if (m_low) fixed.m = M_W'(M_MIN);
    end

    // Settings, change pulse and sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o  <= CFG_RESET;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (upd_en) begin
                word_o  <= fixed;
                valid_o <= (fixed != word_o);
                if (r_low || m_low) err_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/divcfg_serial_port.sv
// Module: divcfg_serial_port
// Three-pin serial configuration port for synthesizer divider settings.
// The pins are synchronized to clk. Serial clock rises shift the frame. The
// active settings update on a load rise, and on every shift while load is high.
// Assumes each pin level lasts at least two clk cycles.
module divcfg_serial_port
    import divcfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk_i,
    input  logic             ser_data_i,
    input  logic             ser_load_i,
    output logic [R_W-1:0]   r_div_o,
    output logic [M_W-1:0]   m_div_o,
    output logic             wide_bw_o,
    output logic [TST_W-1:0] test_bits_o,
    output logic             cfg_valid_o,
    output logic             range_err_o
);
    localparam int PIN_N  = 3;
    localparam int PIN_CK = 0;
    localparam int PIN_DT = 1;
    localparam int PIN_LD = 2;

    logic [PIN_N-1:0]   pin_lvl;
    logic [1:0]         rise;
    logic               clk_lvl;
    logic               data_lvl;
    logic               load_lvl;
    logic               clk_rise;
    logic               load_rise;
    logic               upd_en;
    logic [FRAME_W-1:0] frame_nxt;
    cfg_word_t          word;

    divcfg_pin_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i ({ser_load_i, ser_data_i, ser_clk_i}),
        .lvl_o (pin_lvl)
    );

    assign clk_lvl  = pin_lvl[PIN_CK];
    assign data_lvl = pin_lvl[PIN_DT];
    assign load_lvl = pin_lvl[PIN_LD];

    divcfg_edge_det #(.WIDTH(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  ({load_lvl, clk_lvl}),
        .rise_o (rise)
    );

    assign clk_rise  = rise[0];
    assign load_rise = rise[1];

    divcfg_frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .shift_en    (clk_rise),
        .din         (data_lvl),
        .frame_nxt_o (frame_nxt)
    );

    // Transfer on a load rise; pass shifts through while load stays high.
    always_comb begin
        upd_en = load_lvl && (load_rise || clk_rise);
    end

    divcfg_active_regs u_act (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (upd_en),
        .frame_i (frame_nxt),
        .word_o  (word),
        .valid_o (cfg_valid_o),
        .err_o   (range_err_o)
    );

    assign r_div_o     = word.r;
    assign m_div_o     = word.m;
    assign wide_bw_o   = word.wide_bw;
    assign test_bits_o = word.tst;
endmodule

// File: rtl/divcfg_serial_port_chk.sv
// Module: divcfg_serial_port_chk
// Property checker bound to divcfg_serial_port. It watches the outputs and the
// synchronized load level.
module divcfg_serial_port_chk
    import divcfg_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             load_lvl,
    input logic [R_W-1:0]   r_div_o,
    input logic [M_W-1:0]   m_div_o,
    input logic             wide_bw_o,
    input logic [TST_W-1:0] test_bits_o,
    input logic             cfg_valid_o,
    input logic             range_err_o
);
    logic [FRAME_W-1:0] outs;
    assign outs = {wide_bw_o, test_bits_o, r_div_o, m_div_o};

    AST_R_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        r_div_o != '0);  // R8
    AST_M_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        m_div_o >= M_W'(M_MIN));  // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        range_err_o |=> range_err_o);  // R10
    AST_LOAD_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_lvl |=> $stable(outs));  // R3
    AST_PULSE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid_o |-> !$stable(outs));  // R11
    AST_NO_SILENT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid_o |-> $stable(outs));  // R11
endmodule

bind divcfg_serial_port divcfg_serial_port_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_lvl    (load_lvl),
    .r_div_o     (r_div_o),
    .m_div_o     (m_div_o),
    .wide_bw_o   (wide_bw_o),
    .test_bits_o (test_bits_o),
    .cfg_valid_o (cfg_valid_o),
    .range_err_o (range_err_o)
);

// File: tb/divcfg_serial_port_test.sv
// Bench for divcfg_serial_port: a behavioural model runs each clock and is
// compared every cycle; directed checks cover each requirement.
module divcfg_serial_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_data = 1'b0;
    logic       ser_load = 1'b0;
    logic [8:0] r_div;
    logic [9:0] m_div;
    logic       wide_bw;
    logic [1:0] test_bits;
    logic       cfg_valid;
    logic       range_err;

    int checks = 0;
    int fails = 0;
    int vcnt = 0;
    bit done = 1'b0;
    string creq = "R1";

    always #10 clk = ~clk;

    divcfg_serial_port uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_clk_i   (ser_clk),
        .ser_data_i  (ser_data),
        .ser_load_i  (ser_load),
        .r_div_o     (r_div),
        .m_div_o     (m_div),
        .wide_bw_o   (wide_bw),
        .test_bits_o (test_bits),
        .cfg_valid_o (cfg_valid),
        .range_err_o (range_err)
    );

    // Behavioural model: pins seen two edges late, then edge detection.
    logic [2:0] hist[$];
    logic [2:0] cur, prv;
    int msr, mr, mm, mbw, mt, mv, me;
    int nr, nm, nbw, nt;
    always @(posedge clk) begin
        if (!rst_n) begin
            hist = {3'b0, 3'b0, 3'b0};
            msr = 0; mr = 1; mm = 32; mbw = 1; mt = 0; mv = 0; me = 0;
        end else begin
            cur = hist[1];
            prv = hist[2];
            if (cur[0] && !prv[0]) msr = ((msr << 1) | int'(cur[1])) & 32'h3FFFFF;
            mv = 0;
            if (cur[2] && ((cur[0] && !prv[0]) || !prv[2])) begin
                nbw = (msr >> 21) & 1;
                nt  = (msr >> 19) & 3;
                nr  = (msr >> 10) & 511;
                nm  = msr & 1023;
                if (nr == 0) begin nr = 1; me = 1; end
                if (nm < 4)  begin nm = 4; me = 1; end
                if (nr != mr || nm != mm || nbw != mbw || nt != mt) mv = 1;
                mr = nr; mm = nm; mbw = nbw; mt = nt;
            end
            hist.push_front({ser_load, ser_data, ser_clk});
            void'(hist.pop_back());
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (cfg_valid) vcnt++;
            checks++;
            if (int'(r_div) != mr || int'(m_div) != mm || int'(wide_bw) != mbw ||
                int'(test_bits) != mt || int'(cfg_valid) != mv || int'(range_err) != me) begin
                fails++;
                $display("FAIL [%s] model compare actual r=%0d m=%0d bw=%0d t=%0d v=%0d e=%0d expected r=%0d m=%0d bw=%0d t=%0d v=%0d e=%0d",
                         creq, r_div, m_div, wide_bw, test_bits, cfg_valid, range_err,
                         mr, mm, mbw, mt, mv, me);
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL [%s] %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ser_bit(logic b);
        ser_data = b; ser_clk = 1'b0; wait_n(3);
        ser_clk = 1'b1; wait_n(3);
        ser_clk = 1'b0;
    endtask

    task automatic send_frame(logic [21:0] f);
        for (int i = 21; i >= 0; i--) ser_bit(f[i]);
        wait_n(4);
    endtask

    task automatic pulse_load();
        ser_load = 1'b1; wait_n(5);
        ser_load = 1'b0; wait_n(5);
    endtask

    function automatic logic [21:0] mk(logic bw, logic [1:0] t, int r, int m);
        return {bw, t, 9'(r), 10'(m)};
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL [R4] watchdog actual=timeout expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [21:0] f;
        int v0;
        wait_n(4);
        rst_n = 1'b1;
        wait_n(1);
        creq = "R1";
        chk("R1", "reset r", r_div, 1);
        chk("R1", "reset m", m_div, 32);
        chk("R1", "reset bw", wide_bw, 1);
        chk("R1", "reset test", test_bits, 0);
        chk("R1", "reset err", range_err, 0);
        chk("R1", "reset valid", cfg_valid, 0);

        creq = "R3";
        send_frame(mk(1'b1, 2'b00, 5, 100));
        chk("R3", "r held during shift", r_div, 1);
        chk("R3", "m held during shift", m_div, 32);

        creq = "R4";
        v0 = vcnt;
        ser_load = 1'b1;
        wait_n(2);
        chk("R4", "r before third edge", r_div, 1);
        wait_n(1);
        chk("R4", "r on third edge", r_div, 5);
        chk("R2", "m after transfer", m_div, 100);
        chk("R12", "bw after transfer", wide_bw, 1);
        wait_n(2);
        chk("R11", "one pulse on transfer", vcnt - v0, 1);
        ser_load = 1'b0; wait_n(5);

        creq = "R5";
        f = mk(1'b0, 2'b11, 300, 777);
        send_frame(f);
        chk("R5", "r frozen after fall", r_div, 5);
        chk("R5", "m frozen after fall", m_div, 100);

        creq = "R6";
        ser_load = 1'b1; wait_n(5);
        chk("R2", "r 300", r_div, 300);
        chk("R2", "m 777", m_div, 777);
        chk("R12", "bw narrow", wide_bw, 0);
        chk("R12", "test bits", test_bits, 3);
        ser_bit(1'b1); wait_n(4);
        f = {f[20:0], 1'b1};
        chk("R6", "transparent r", r_div, int'(f[18:10]));
        chk("R6", "transparent m", m_div, int'(f[9:0]));
        ser_bit(1'b0); wait_n(4);
        f = {f[20:0], 1'b0};
        chk("R6", "transparent m second", m_div, int'(f[9:0]));
        ser_load = 1'b0; wait_n(5);

        creq = "R7";
        f = mk(1'b1, 2'b00, 17, 513);
        for (int i = 21; i >= 1; i--) ser_bit(f[i]);
        ser_data = f[0]; wait_n(3);
        ser_clk = 1'b1; ser_load = 1'b1; wait_n(5);
        chk("R7", "coincident r", r_div, 17);
        chk("R7", "coincident m", m_div, 513);
        ser_clk = 1'b0; wait_n(3);
        ser_load = 1'b0; wait_n(5);

        creq = "R11";
        v0 = vcnt;
        pulse_load();
        chk("R11", "no pulse on equal update", vcnt - v0, 0);

        creq = "R10";
        rst_n = 1'b0; wait_n(2); rst_n = 1'b1; wait_n(1);
        chk("R10", "err clear after reset", range_err, 0);
        send_frame(mk(1'b1, 2'b00, 511, 1023)); pulse_load();
        chk("R2", "max r", r_div, 511);
        chk("R2", "max m", m_div, 1023);
        chk("R10", "err low for legal frame", range_err, 0);

        creq = "R8";
        send_frame(mk(1'b1, 2'b00, 0, 50)); pulse_load();
        chk("R8", "r zero clamped", r_div, 1);
        chk("R8", "m alongside", m_div, 50);
        chk("R10", "err set", range_err, 1);

        creq = "R9";
        send_frame(mk(1'b1, 2'b00, 3, 2)); pulse_load();
        chk("R9", "m 2 clamped", m_div, 4);
        send_frame(mk(1'b1, 2'b00, 3, 4)); pulse_load();
        chk("R9", "m 4 kept", m_div, 4);
        send_frame(mk(1'b1, 2'b00, 3, 5)); pulse_load();
        chk("R9", "m 5 kept", m_div, 5);
        chk("R10", "err still set", range_err, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule